// File: doc/BRIEF.md
# Converter power and calibration sequencer

This block sequences one analog-to-digital converter core through power-down, wake-up, standby and calibration, all in the converter clock domain. Raising the enable starts a wake-up interval and queues a self-calibration. The ready flag rises only once that first calibration has completed. Calibration requests come from software, from the self-calibration queued at power-up, or from a periodic recalibration timer driven by a one-second tick. A queued request is launched on the analog side only after a selectable run of cycles with no converter activity.

The block also contains a free-running repeat timer that emits a periodic conversion trigger while the core is on. It also guards a test-enable bit with a lock: while the lock is held, the bit can be cleared but not set. Register access, channel sequencing and the converter itself sit outside the block. The block only sees the relevant bits as plain inputs.

Top module: `adc_pwr_cal_seq`

## Requirements
- R1: After reset with enable low, mode reads 00 and ready, calibration-done, calibration-request, calibration-start, trigger and test-enable all read 0.
- R2: When enable rises, or standby drops while enabled, the mode reads 01 for exactly WAKE_CYC clock cycles and then reads 10 (on).
- R3: A pending request starts calibration only after a run of activity-free cycles. The run length is 2, 4, 8 or 16 for idle-select codes 00, 01, 10 and 11. A pulse appears on cal_start_o in the cycle after the run completes, so the latency from activity dropping is the run length plus 1. Any active cycle restarts the run.
- R4: A one-cycle pulse on cal_req_set_i sets cal_req_o. cal_req_o clears in the same edge that raises cal_start_o, and cal_start_o lasts exactly one cycle.
- R5: cal_done_o reads 0 from the start of a calibration until cal_done_i is seen. It then reads 1.
- R6: ready_o reads 0 until the first calibration after enable has completed. It then reads 1, and it stays 1 through standby.
- R7: With auto-recalibration on, a recalibration request is raised every 1, 64, 1024 or 4096 ticks for rate codes 00, 01, 10 and 11. A change of rate code or auto enable restarts the count.
- R8: While the core is on, trig_o pulses once every N+1 clocks, where N is the 6-bit repeat value.
- R9: A write with data 0 clears test-enable. A write with data 1 sets it only while the lock is 0. While the lock is 1, the write leaves the bit unchanged.
- R10: Enable low sends the block to power-down at the next edge. This clears ready, calibration-done and any pending request, and aborts any running calibration. Requests made while disabled are discarded.
- R11: Raising standby while on gives mode 01 at the next edge. No calibration starts while the core is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable |
| stby_i | input | 1 | Standby request |
| cal_req_set_i | input | 1 | Software calibration request pulse |
| acal_en_i | input | 1 | Auto-recalibration enable |
| cal_rate_i | input | 2 | Recalibration period code |
| idle_sel_i | input | 2 | Activity-free run length code |
| busy_i | input | 1 | Converter activity in this cycle |
| sec_tick_i | input | 1 | One-cycle pulse each second, already synchronised to clk |
| cal_done_i | input | 1 | Calibration finished, from the analog side |
| rpt_val_i | input | RPT_W | Repeat trigger value N (period N+1) |
| tst_wr_i | input | 1 | Test-enable write strobe |
| tst_wdata_i | input | 1 | Test-enable write data |
| tst_lock_i | input | 1 | Test-enable lock |
| cal_start_o | output | 1 | Calibration start strobe to the analog side |
| cal_req_o | output | 1 | Calibration request pending |
| cal_done_o | output | 1 | Calibration finished flag |
| ready_o | output | 1 | Powered up and self-calibrated |
| mode_o | output | 2 | 00 off, 01 standby or waking, 10 on |
| trig_o | output | 1 | Periodic conversion trigger |
| tst_en_o | output | 1 | Test-enable bit |

## Verification
The bench builds the block with WAKE_CYC at 12 instead of 230, so every wake interval can be counted cycle by cycle while the other widths keep their defaults. The 6-bit repeat field is swept over all 64 values, and every idle-select and rate code is exercised, as are all eight combinations of prior value, lock and write data for the test bit. Driving the seconds tick on every cycle brings the 4096-tick recalibration period within a few thousand clocks. A slower tick covers the one-tick code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_WAKE,
      ST_RUN,
      ST_CAL,
      ST_STBY
   } seq_state_e;

   localparam logic [1:0] MODE_OFF  = 2'b00;
   localparam logic [1:0] MODE_STBY = 2'b01;
   localparam logic [1:0] MODE_ON   = 2'b10;

   localparam int IDLE_W  = 5;
   localparam int RECAL_W = 13;

   // activity-free cycles needed before a calibration launch
   function automatic logic [IDLE_W-1:0] idle_need(input logic [1:0] sel);
      return IDLE_W'(2) << sel;
   endfunction

   // recalibration period in seconds ticks
   function automatic logic [RECAL_W-1:0] recal_period(input logic [1:0] code);
      logic [RECAL_W-1:0] p;
      case (code)
         2'b00:   p = RECAL_W'(1);
         2'b01:   p = RECAL_W'(64);
         2'b10:   p = RECAL_W'(1024);
         default: p = RECAL_W'(4096);
      endcase
      return p;
   endfunction

endpackage

// File: rtl/adc_idle_gate.sv
module adc_idle_gate
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr_i,
   input  logic       busy_i,
   input  logic [1:0] sel_i,
   output logic       ok_o
);

   logic [IDLE_W-1:0] quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet_q <= '0;
      end else if (clr_i || busy_i) begin
         quiet_q <= '0;
      end else if (quiet_q != '1) begin
         quiet_q <= quiet_q + 1'b1;
      end
   end

   assign ok_o = (quiet_q >= idle_need(sel_i));

endmodule

// File: rtl/adc_recal_timer.sv
module adc_recal_timer
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic [1:0] rate_i,
   input  logic       tick_i,
   output logic       fire_o
);

   logic [RECAL_W-1:0] ticks_q;
   logic [2:0]         cfg_q;
   logic [2:0]         cfg_now;
   logic [RECAL_W-1:0] last_tick;

   assign cfg_now   = {run_i, rate_i};
   assign last_tick = recal_period(rate_i) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks_q <= '0;
         cfg_q   <= '0;
         fire_o  <= 1'b0;
      end else begin
         fire_o <= 1'b0;
         if (cfg_now != cfg_q) begin
            cfg_q   <= cfg_now;
            ticks_q <= '0;
         end else if (run_i && tick_i) begin
            if (ticks_q >= last_tick) begin
               ticks_q <= '0;
               fire_o  <= 1'b1;
            end else begin
               ticks_q <= ticks_q + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/adc_rpt_timer.sv
module adc_rpt_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] last_i,
   output logic         trig_o
);

   if (W < 1) begin : g_bad_w
      $error("adc_rpt_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trig_o <= 1'b0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         trig_o <= 1'b0;
      end else if (cnt_q >= last_i) begin
         cnt_q  <= '0;
         trig_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         trig_o <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_pwr_cal_seq.sv
module adc_pwr_cal_seq
   import adc_seq_pkg::*;
#(
   parameter int WAKE_CYC = 230,
   parameter int RPT_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             stby_i,
   input  logic             cal_req_set_i,
   input  logic             acal_en_i,
   input  logic [1:0]       cal_rate_i,
   input  logic [1:0]       idle_sel_i,
   input  logic             busy_i,
   input  logic             sec_tick_i,
   input  logic             cal_done_i,
   input  logic [RPT_W-1:0] rpt_val_i,
   input  logic             tst_wr_i,
   input  logic             tst_wdata_i,
   input  logic             tst_lock_i,
   output logic             cal_start_o,
   output logic             cal_req_o,
   output logic             cal_done_o,
   output logic             ready_o,
   output logic [1:0]       mode_o,
   output logic             trig_o,
   output logic             tst_en_o
);

   localparam int WK_W = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
   localparam logic [WK_W-1:0] WK_LOAD = WK_W'(WAKE_CYC - 1);

   if (WAKE_CYC < 2) begin : g_bad_wake
      $error("adc_pwr_cal_seq: WAKE_CYC must be at least 2");
   end

   seq_state_e      state_q;
   logic [WK_W-1:0] wake_q;
   logic            idle_ok;
   logic            recal_fire;
   logic            core_on;

   assign core_on = (state_q == ST_RUN) || (state_q == ST_CAL);

   adc_idle_gate u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (state_q != ST_RUN),
      .busy_i (busy_i),
      .sel_i  (idle_sel_i),
      .ok_o   (idle_ok)
   );

   adc_recal_timer u_recal (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (en_i && acal_en_i),
      .rate_i (cal_rate_i),
      .tick_i (sec_tick_i),
      .fire_o (recal_fire)
   );

   adc_rpt_timer #(.W(RPT_W)) u_rpt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (core_on),
      .last_i (rpt_val_i),
      .trig_o (trig_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_OFF;
         wake_q      <= '0;
         cal_req_o   <= 1'b0;
         cal_start_o <= 1'b0;
         cal_done_o  <= 1'b0;
         ready_o     <= 1'b0;
      end else begin
         cal_start_o <= 1'b0;
         if (!en_i) begin
            state_q    <= ST_OFF;
            cal_req_o  <= 1'b0;
            cal_done_o <= 1'b0;
            ready_o    <= 1'b0;
         end else begin
            if (cal_req_set_i || recal_fire) begin
               cal_req_o <= 1'b1;
            end
            case (state_q)
               ST_OFF: begin
                  state_q   <= ST_WAKE;
                  wake_q    <= WK_LOAD;
                  cal_req_o <= 1'b1;
               end
               ST_WAKE: begin
                  if (wake_q == '0) begin
                     state_q <= ST_RUN;
                  end else begin
                     wake_q <= wake_q - 1'b1;
                  end
               end
               ST_RUN: begin
                  if (stby_i) begin
                     state_q <= ST_STBY;
                  end else if (cal_req_o && idle_ok) begin
                     state_q     <= ST_CAL;
                     cal_start_o <= 1'b1;
                     cal_req_o   <= 1'b0;
                     cal_done_o  <= 1'b0;
                  end
               end
               ST_CAL: begin
                  if (cal_done_i) begin
                     state_q    <= ST_RUN;
                     cal_done_o <= 1'b1;
                     ready_o    <= 1'b1;
                  end
               end
               ST_STBY: begin
                  if (!stby_i) begin
                     state_q <= ST_WAKE;
                     wake_q  <= WK_LOAD;
                  end
               end
               default: state_q <= ST_OFF;
            endcase
         end
      end
   end

   always_comb begin
      case (state_q)
         ST_OFF:          mode_o = MODE_OFF;
         ST_WAKE, ST_STBY: mode_o = MODE_STBY;
         default:         mode_o = MODE_ON;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tst_en_o <= 1'b0;
      end else if (tst_wr_i) begin
         if (!tst_wdata_i) begin
            tst_en_o <= 1'b0;
         end else if (!tst_lock_i) begin
            tst_en_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/adc_pwr_cal_seq_chk.sv
module adc_pwr_cal_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_i,
   input logic       busy_i,
   input logic       cal_done_i,
   input logic       tst_wr_i,
   input logic       tst_lock_i,
   input logic       cal_start_o,
   input logic       cal_req_o,
   input logic       cal_done_o,
   input logic       ready_o,
   input logic [1:0] mode_o,
   input logic       tst_en_o
);

   a_r10_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (mode_o == 2'b00 && !ready_o && !cal_done_o && !cal_req_o));

   a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |=> !cal_start_o);

   a_r4_req_taken: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |-> !cal_req_o);

   a_r5_done_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |-> !cal_done_o);

   a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(cal_done_i));

   a_r6_ready_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (mode_o != 2'b00));

   a_r3_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      cal_start_o |-> (!$past(busy_i, 2) && !$past(busy_i, 3)));

   a_r9_lock_blocks_set: assert property (@(posedge clk) disable iff (!rst_n)
      (tst_wr_i && tst_lock_i && !tst_en_o) |=> !tst_en_o);

endmodule

bind adc_pwr_cal_seq adc_pwr_cal_seq_chk u_chk (.*);

// File: tb/adc_pwr_cal_seq_bench.sv
module adc_pwr_cal_seq_bench;

   localparam int WK    = 12;
   localparam int RPT_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en_i = 0, stby_i = 0, cal_req_set_i = 0, acal_en_i = 0;
   logic [1:0]       cal_rate_i = 0, idle_sel_i = 0;
   logic             busy_i = 0, sec_tick_i = 0, cal_done_i = 0;
   logic [RPT_W-1:0] rpt_val_i = 0;
   logic             tst_wr_i = 0, tst_wdata_i = 0, tst_lock_i = 0;
   logic             cal_start_o, cal_req_o, cal_done_o, ready_o, trig_o, tst_en_o;
   logic [1:0]       mode_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   int resp_dly = 0;
   int tick_per = 0;
   int tick_cnt = 0;

   always #10 clk = ~clk;

   adc_pwr_cal_seq #(.WAKE_CYC(WK), .RPT_W(RPT_W)) u_adc_pwr_cal_seq (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .stby_i(stby_i),
      .cal_req_set_i(cal_req_set_i), .acal_en_i(acal_en_i),
      .cal_rate_i(cal_rate_i), .idle_sel_i(idle_sel_i), .busy_i(busy_i),
      .sec_tick_i(sec_tick_i), .cal_done_i(cal_done_i), .rpt_val_i(rpt_val_i),
      .tst_wr_i(tst_wr_i), .tst_wdata_i(tst_wdata_i), .tst_lock_i(tst_lock_i),
      .cal_start_o(cal_start_o), .cal_req_o(cal_req_o), .cal_done_o(cal_done_o),
      .ready_o(ready_o), .mode_o(mode_o), .trig_o(trig_o), .tst_en_o(tst_en_o)
   );

   // analog-side model: answer each start with a done pulse a few cycles later
   always @(negedge clk) begin
      cal_done_i <= (resp_dly == 1);
      if (resp_dly > 0) resp_dly <= resp_dly - 1;
      if (cal_start_o) resp_dly <= 3;
   end

   // seconds tick generator
   always @(negedge clk) begin
      if (tick_per == 0) begin
         sec_tick_i <= 1'b0;
         tick_cnt   <= 0;
      end else begin
         sec_tick_i <= (tick_cnt == 0);
         tick_cnt   <= (tick_cnt >= tick_per - 1) ? 0 : tick_cnt + 1;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_start(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n = n + 1;
      end while (!cal_start_o && n < 20000);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 50 && !cal_done_o; i++) @(negedge clk);
   endtask

   task automatic wait_trig(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n = n + 1;
      end while (!trig_o && n < 500);
   endtask

   task automatic tst_write(input bit lock, input bit data);
      @(negedge clk);
      tst_lock_i = lock; tst_wdata_i = data; tst_wr_i = 1'b1;
      @(negedge clk);
      tst_wr_i = 1'b0;
   endtask

   initial begin
      int n;
      int ok_cnt;
      int need;
      bit early;
      bit exp_en;
      bit prior;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mode_o == 2'b00, "R1 mode", mode_o, 0);
      chk(!ready_o && !cal_done_o && !cal_req_o && !cal_start_o && !trig_o && !tst_en_o,
          "R1 flags", {ready_o, cal_done_o, cal_req_o, cal_start_o, trig_o, tst_en_o}, 0);

      // R10 request while disabled is discarded
      cal_req_set_i = 1; @(negedge clk); cal_req_set_i = 0; @(negedge clk);
      chk(!cal_req_o, "R10 req while off", cal_req_o, 0);

      // R2 power-up wake interval; busy held so self-cal waits
      busy_i = 1;
      en_i   = 1;
      n = 0;
      ok_cnt = 0;
      do begin
         @(negedge clk);
         n = n + 1;
         if (mode_o == 2'b01) ok_cnt = ok_cnt + 1;
      end while (mode_o != 2'b10 && n < 100);
      chk(n == WK + 1, "R2 power-up length", n, WK + 1);
      chk(ok_cnt == WK, "R2 mode 01 while waking", ok_cnt, WK);
      chk(!ready_o, "R6 not ready before self-cal", ready_o, 0);
      chk(cal_req_o, "R4 self-cal queued", cal_req_o, 1);

      // self-calibration, idle code 00
      busy_i = 0;
      wait_start(n);
      chk(n == 3, "R3 self-cal latency", n, 3);
      chk(!cal_req_o, "R4 req cleared at start", cal_req_o, 0);
      chk(!cal_done_o, "R5 done low while running", cal_done_o, 0);
      @(negedge clk);
      chk(!cal_start_o, "R4 start one cycle", cal_start_o, 0);
      wait_done();
      chk(cal_done_o, "R5 done after finish", cal_done_o, 1);
      chk(ready_o, "R6 ready after self-cal", ready_o, 1);

      // R3 idle-run sweep over all codes
      for (int s = 0; s < 4; s++) begin
         need = 2 << s;
         idle_sel_i = s[1:0];
         busy_i = 1;
         @(negedge clk);
         cal_req_set_i = 1; @(negedge clk); cal_req_set_i = 0;
         chk(cal_req_o, "R4 sw request set", cal_req_o, 1);
         repeat (20) @(negedge clk);
         chk(!cal_start_o && cal_req_o, "R3 held off while busy", cal_start_o, 0);
         busy_i = 0;
         wait_start(n);
         chk(n == need + 1, "R3 idle latency", n, need + 1);
         wait_done();
      end

      // R3 activity restarts the run (code 11)
      busy_i = 1;
      @(negedge clk);
      cal_req_set_i = 1; @(negedge clk); cal_req_set_i = 0;
      busy_i = 0;
      early = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (cal_start_o) early = 1;
      end
      busy_i = 1; @(negedge clk); busy_i = 0;
      chk(!early, "R3 no start inside run", early, 0);
      wait_start(n);
      chk(n == 17, "R3 restart after activity", n, 17);
      wait_done();
      idle_sel_i = 0;

      // R11 standby and R2 recovery
      stby_i = 1;
      @(negedge clk);
      chk(mode_o == 2'b01, "R11 standby mode", mode_o, 1);
      busy_i = 0;
      cal_req_set_i = 1; @(negedge clk); cal_req_set_i = 0;
      repeat (30) @(negedge clk);
      chk(!cal_done_o || cal_req_o, "R11 no cal in standby", cal_req_o, 1);
      chk(ready_o, "R6 ready kept in standby", ready_o, 1);
      busy_i = 1;
      stby_i = 0;
      n = 0;
      do begin
         @(negedge clk);
         n = n + 1;
      end while (mode_o != 2'b10 && n < 100);
      chk(n == WK + 1, "R2 standby recovery", n, WK + 1);
      busy_i = 0;
      wait_start(n);
      wait_done();

      // R8 repeat trigger, every value
      busy_i = 1;
      for (int v = 0; v < 64; v++) begin
         rpt_val_i = v[RPT_W-1:0];
         wait_trig(n);
         wait_trig(n);
         wait_trig(n);
         chk(n == v + 1, "R8 trigger period", n, v + 1);
      end
      busy_i = 0;

      // R7 recalibration periods
      for (int r = 0; r < 4; r++) begin
         cal_rate_i = r[1:0];
         tick_per   = (r == 0) ? 50 : 1;
         acal_en_i  = 1;
         wait_start(n);
         wait_start(n);
         wait_start(n);
         need = (r == 0) ? 50 : ((r == 1) ? 64 : ((r == 2) ? 1024 : 4096));
         chk(n == need, "R7 recal interval", n, need);
      end
      acal_en_i = 0;
      tick_per  = 0;
      repeat (10) @(negedge clk);

      // R9 test-enable lock, all combinations
      for (int p = 0; p < 2; p++)
         for (int l = 0; l < 2; l++)
            for (int d = 0; d < 2; d++) begin
               prior = p[0];
               tst_write(1'b0, prior);
               exp_en = d[0] ? (l[0] ? prior : 1'b1) : 1'b0;
               tst_write(l[0], d[0]);
               chk(tst_en_o == exp_en, "R9 lock write", tst_en_o, exp_en);
            end

      // R10 enable drop during a running calibration
      cal_req_set_i = 1; @(negedge clk); cal_req_set_i = 0;
      wait_start(n);
      en_i = 0;
      @(negedge clk);
      chk(mode_o == 2'b00, "R10 mode off", mode_o, 0);
      chk(!ready_o && !cal_done_o && !cal_req_o, "R10 flags cleared",
          {ready_o, cal_done_o, cal_req_o}, 0);
      repeat (8) @(negedge clk);
      chk(!ready_o && !cal_done_o && !trig_o, "R10 stays off",
          {ready_o, cal_done_o, trig_o}, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule